// File: doc/BRIEF.md
# Dual-Issue Pairing Unit

This block sits at the end of the fetch stage of a two-way static superscalar pipeline. Every cycle it is handed two fetched instructions, already classified and with their register fields decoded. The older one is entry 0 and the younger one is entry 1. Two class-restricted issue slots follow it. Slot A executes ALU and branch instructions. Slot B executes loads and stores. The block decides whether the pair can go out together, and whether the two must be swapped to reach their slots. Otherwise it issues only the older instruction, or nothing at all when a load result is not yet ready.

The block returns the number of bytes by which fetch must advance the PC. When only the older instruction leaves, fetch re-presents the younger one as entry 0 of the next pair. For this reason the block keeps no instruction storage. Its only state is a record of the load that issued in the previous cycle. That record drives the load-use bubble, which applies to both instructions of the following pair.

Top module: `pair_issue_unit`

## Requirements
- R1: A synchronous active-low reset clears the record of a pending load. After reset, an instruction reading the destination of a load that issued before reset is issued without a stall.
- R2: Class codes are 0 = ALU, 1 = branch, 2 = load, 3 = store, so bit 1 marks a memory class. Slot A only ever carries classes 0 and 1. Slot B only ever carries classes 2 and 3. Each slot outputs the class and the register fields of the instruction it carries, and zeros when it is empty.
- R3: A valid pair with an ALU or branch instruction at entry 0 and a load or store at entry 1 is dual issued when it has no hazard: A takes entry 0 (source 0), B takes entry 1 (source 1), no swap, PC step 8.
- R4: A valid pair with a load or store at entry 0 and an ALU or branch at entry 1 is dual issued swapped when it has no hazard: A takes entry 1, B takes entry 0, swap flag 1, PC step 8.
- R5: A pair whose two instructions belong to the same slot issues only entry 0, into its own slot, with PC step 4.
- R6: In the unswapped order, if entry 1 reads a nonzero register that entry 0 writes, only entry 0 issues (PC step 4).
- R7: A swap is refused when the two instructions have any register dependence between them: entry 1 reads the register entry 0 writes, entry 0 reads the register entry 1 writes, or both write the same register. Only entry 0 then issues. In the unswapped order, entry 0 reading the register entry 1 writes does not block pairing.
- R8: In the cycle after a load with nonzero destination issues, if entry 0 reads that register, nothing issues. The PC step is 0 and the load-stall output is 1.
- R9: In that same cycle, if only entry 1 reads the load destination, entry 0 issues alone with PC step 4.
- R10: The load-use hazard lasts exactly one cycle. The same consumer presented in the next cycle issues normally.
- R11: A write to register 0 creates neither a pairing dependence nor a load-use stall.
- R12: When entry 0 is invalid, nothing issues and the PC step is 0, whatever entry 1 holds. When entry 1 is invalid, entry 0 issues alone.
- R13: ALU and load instructions write their destination field. Branches and stores do not. A load reads only its first source field. All other classes read both source fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| f0_valid | input | 1 | Entry 0 (older) present |
| f0_cls | input | 2 | Entry 0 class code |
| f0_rd | input | 5 | Entry 0 destination register |
| f0_rs1 | input | 5 | Entry 0 first source register |
| f0_rs2 | input | 5 | Entry 0 second source register |
| f1_valid | input | 1 | Entry 1 (younger) present |
| f1_cls | input | 2 | Entry 1 class code |
| f1_rd | input | 5 | Entry 1 destination register |
| f1_rs1 | input | 5 | Entry 1 first source register |
| f1_rs2 | input | 5 | Entry 1 second source register |
| a_valid | output | 1 | Slot A carries an instruction |
| a_src | output | 1 | Entry index routed to slot A |
| a_cls | output | 2 | Slot A class |
| a_rd | output | 5 | Slot A destination |
| a_rs1 | output | 5 | Slot A first source |
| a_rs2 | output | 5 | Slot A second source |
| b_valid | output | 1 | Slot B carries an instruction |
| b_src | output | 1 | Entry index routed to slot B |
| b_cls | output | 2 | Slot B class |
| b_rd | output | 5 | Slot B destination |
| b_rs1 | output | 5 | Slot B first source |
| b_rs2 | output | 5 | Slot B second source |
| swapped | output | 1 | Pair issued in reversed order |
| pc_inc | output | 4 | Bytes fetch advances this cycle (0, 4 or 8) |
| load_stall | output | 1 | Load-use bubble this cycle |

## Verification
The hardest situation to bring about is a swapped pair that is blocked only by a write-after-read or write-after-write relation. It must be told apart from the same relation in unswapped order, which must still dual issue. The stimulus builds both orders from the same register numbers and checks that one gives a PC step of 4 and the other 8. The load-use cases need a load to leave through slot B exactly one cycle before the consumer pair. Each such test therefore issues the load alone and presents the consumer in the very next cycle. It then repeats the consumer, or presents the held instruction, to show the bubble lasts one cycle. Because every load that reaches slot B leaves a pending hazard, an idle cycle follows each test that issues one.

// File: rtl/pair_issue_pkg.sv
// Package: shared constants, class encoding and register-usage helpers
// for the dual-issue pairing unit.
// Assumes: five-bit register indices, register 0 is a constant sink.
package pair_issue_pkg;
    parameter int REG_W      = 5;
    parameter int INSN_BYTES = 4;
    parameter int N_ENTRY    = 2;
    localparam int INC_W     = $clog2(2 * INSN_BYTES + 1);

    typedef enum logic [1:0] {
        CLS_ALU    = 2'd0,
        CLS_BRANCH = 2'd1,
        CLS_LOAD   = 2'd2,
        CLS_STORE  = 2'd3
    } insn_cls_e;

    // True when an instruction of this class updates a nonzero destination.
    function automatic logic writes_reg(input logic [1:0] cls,
                                        input logic [REG_W-1:0] rd);
        return ((cls == CLS_ALU) || (cls == CLS_LOAD)) && (rd != '0);
    endfunction

    // True when an instruction of this class reads nonzero register r.
    function automatic logic reads_reg(input logic [1:0] cls,
                                       input logic [REG_W-1:0] rs1,
                                       input logic [REG_W-1:0] rs2,
                                       input logic [REG_W-1:0] r);
        return (r != '0) &&
               ((rs1 == r) || ((cls != CLS_LOAD) && (rs2 == r)));
    endfunction
endpackage

// File: rtl/pair_hazard.sv
// Module: pair_hazard
// Finds register relations inside the fetched pair and against the load
// that issued in the previous cycle.
// Assumes: the entry 0 is older than entry 1; pend_rd is nonzero when pend.
module pair_hazard
    import pair_issue_pkg::*;
(
    input  logic [N_ENTRY-1:0][1:0]       cls,
    input  logic [N_ENTRY-1:0][REG_W-1:0] rd,
    input  logic [N_ENTRY-1:0][REG_W-1:0] rs1,
    input  logic [N_ENTRY-1:0][REG_W-1:0] rs2,
    input  logic                          pend,
    input  logic [REG_W-1:0]              pend_rd,
    output logic                          raw01,
    output logic                          any_dep,
    output logic [N_ENTRY-1:0]            lu_hit
);
    logic war10;
    logic waw01;

    // Per-entry check against the pending load destination.
    for (genvar e = 0; e < N_ENTRY; e++) begin : g_lu
        assign lu_hit[e] = pend && reads_reg(cls[e], rs1[e], rs2[e], pend_rd);
    end

    // Relations between the two entries of the pair.
    always_comb begin
        raw01   = writes_reg(cls[0], rd[0]) &&
                  reads_reg(cls[1], rs1[1], rs2[1], rd[0]);
        war10   = writes_reg(cls[1], rd[1]) &&
                  reads_reg(cls[0], rs1[0], rs2[0], rd[1]);
        waw01   = writes_reg(cls[0], rd[0]) && writes_reg(cls[1], rd[1]) &&
                  (rd[0] == rd[1]);
        any_dep = raw01 || war10 || waw01;
    end
endmodule

// File: rtl/pair_ctl.sv
// Module: pair_ctl
// Chooses between dual issue, single issue of the older entry, or a
// bubble, and produces the PC step.
// Assumes: bit 1 of a class code marks a load/store.
module pair_ctl
    import pair_issue_pkg::*;
(
    input  logic [N_ENTRY-1:0]      valid,
    input  logic [N_ENTRY-1:0]      is_mem,
    input  logic                    raw01,
    input  logic                    any_dep,
    input  logic [N_ENTRY-1:0]      lu_hit,
    output logic                    can_pair,
    output logic                    issue_old,
    output logic                    swap,
    output logic                    bubble,
    output logic [INC_W-1:0]        pc_step
);
    localparam logic [INC_W-1:0] STEP_ONE = INC_W'(INSN_BYTES);
    localparam logic [INC_W-1:0] STEP_TWO = INC_W'(2 * INSN_BYTES);

    logic order_ok;

    // Pairing is legal when slots differ and the order-specific dependence rule passes.
    always_comb begin
        order_ok  = is_mem[0] ? !any_dep : !raw01;
        bubble    = valid[0] && lu_hit[0];
        issue_old = valid[0] && !lu_hit[0];
        can_pair  = issue_old && valid[1] && !lu_hit[1] &&
                    (is_mem[0] != is_mem[1]) && order_ok;
        swap      = can_pair && is_mem[0];
    end

    // PC advance for the fetch stage.
    always_comb begin
        if (can_pair)       pc_step = STEP_TWO;
        else if (issue_old) pc_step = STEP_ONE;
        else                pc_step = '0;
    end
endmodule

// File: rtl/pair_slot_mux.sv
// Module: pair_slot_mux
// Routes the chosen entries into slot 0 (ALU/branch) and slot 1
// (load/store), zeroing an empty slot.
// Assumes: can_pair implies the two entries belong to different slots.
module pair_slot_mux
    import pair_issue_pkg::*;
(
    input  logic                          can_pair,
    input  logic                          issue_old,
    input  logic [N_ENTRY-1:0][1:0]       cls,
    input  logic [N_ENTRY-1:0][REG_W-1:0] rd,
    input  logic [N_ENTRY-1:0][REG_W-1:0] rs1,
    input  logic [N_ENTRY-1:0][REG_W-1:0] rs2,
    output logic [N_ENTRY-1:0]            s_valid,
    output logic [N_ENTRY-1:0]            s_src,
    output logic [N_ENTRY-1:0][1:0]       s_cls,
    output logic [N_ENTRY-1:0][REG_W-1:0] s_rd,
    output logic [N_ENTRY-1:0][REG_W-1:0] s_rs1,
    output logic [N_ENTRY-1:0][REG_W-1:0] s_rs2
);
    for (genvar s = 0; s < N_ENTRY; s++) begin : g_slot
        localparam logic SLOT_MEM = 1'(s);
        // Select which entry (if any) feeds this slot and forward its fields.
        always_comb begin
            s_valid[s] = can_pair || (issue_old && (cls[0][1] == SLOT_MEM));
            s_src[s]   = can_pair && (cls[1][1] == SLOT_MEM);
            if (s_valid[s]) begin
                s_cls[s] = cls[s_src[s]];
                s_rd[s]  = rd[s_src[s]];
                s_rs1[s] = rs1[s_src[s]];
                s_rs2[s] = rs2[s_src[s]];
            end else begin
                s_cls[s] = '0;
                s_rd[s]  = '0;
                s_rs1[s] = '0;
                s_rs2[s] = '0;
            end
        end
    end
endmodule

// File: rtl/pair_load_track.sv
// Module: pair_load_track
// Remembers the destination of a load that left through the memory slot
// this cycle, so the next pair can be checked for a load-use hazard.
// Assumes: a load result is usable two cycles after issue.
module pair_load_track
    import pair_issue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_valid,
    input  logic [1:0]       mem_cls,
    input  logic [REG_W-1:0] mem_rd,
    output logic             pend,
    output logic [REG_W-1:0] pend_rd
);
    // Capture a load with a nonzero destination; anything else clears the record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            pend_rd <= '0;
        end else begin
            pend    <= mem_valid && (mem_cls == CLS_LOAD) && (mem_rd != '0);
            pend_rd <= mem_rd;
        end
    end
endmodule

// File: rtl/pair_issue_unit.sv
// Module: pair_issue_unit
// Top of the dual-issue pairing logic: hazard detection, pairing decision,
// slot steering and load tracking.
// Assumes: fetch re-presents a held younger entry as entry 0 next cycle.
module pair_issue_unit
    import pair_issue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             f0_valid,
    input  logic [1:0]       f0_cls,
    input  logic [REG_W-1:0] f0_rd,
    input  logic [REG_W-1:0] f0_rs1,
    input  logic [REG_W-1:0] f0_rs2,
    input  logic             f1_valid,
    input  logic [1:0]       f1_cls,
    input  logic [REG_W-1:0] f1_rd,
    input  logic [REG_W-1:0] f1_rs1,
    input  logic [REG_W-1:0] f1_rs2,
    output logic             a_valid,
    output logic             a_src,
    output logic [1:0]       a_cls,
    output logic [REG_W-1:0] a_rd,
    output logic [REG_W-1:0] a_rs1,
    output logic [REG_W-1:0] a_rs2,
    output logic             b_valid,
    output logic             b_src,
    output logic [1:0]       b_cls,
    output logic [REG_W-1:0] b_rd,
    output logic [REG_W-1:0] b_rs1,
    output logic [REG_W-1:0] b_rs2,
    output logic             swapped,
    output logic [INC_W-1:0] pc_inc,
    output logic             load_stall
);
    localparam logic [INC_W-1:0] PAIR_STEP = INC_W'(2 * INSN_BYTES);

    logic [N_ENTRY-1:0]            e_valid;
    logic [N_ENTRY-1:0][1:0]       e_cls;
    logic [N_ENTRY-1:0][REG_W-1:0] e_rd, e_rs1, e_rs2;
    logic [N_ENTRY-1:0]            e_mem;
    logic                          raw01, any_dep, can_pair, issue_old, swap;
    logic [N_ENTRY-1:0]            lu_hit;
    logic                          pend;
    logic [REG_W-1:0]              pend_rd;
    logic [N_ENTRY-1:0]            s_valid, s_src;
    logic [N_ENTRY-1:0][1:0]       s_cls;
    logic [N_ENTRY-1:0][REG_W-1:0] s_rd, s_rs1, s_rs2;

    // Gather the two fetched entries into indexed form.
    always_comb begin
        e_valid = {f1_valid, f0_valid};
        e_cls   = {f1_cls, f0_cls};
        e_rd    = {f1_rd, f0_rd};
        e_rs1   = {f1_rs1, f0_rs1};
        e_rs2   = {f1_rs2, f0_rs2};
        e_mem   = {f1_cls[1], f0_cls[1]};
    end

    pair_hazard u_hazard (
        .cls(e_cls), .rd(e_rd), .rs1(e_rs1), .rs2(e_rs2),
        .pend(pend), .pend_rd(pend_rd),
        .raw01(raw01), .any_dep(any_dep), .lu_hit(lu_hit)
    );

    pair_ctl u_ctl (
        .valid(e_valid), .is_mem(e_mem), .raw01(raw01), .any_dep(any_dep),
        .lu_hit(lu_hit), .can_pair(can_pair), .issue_old(issue_old),
        .swap(swap), .bubble(load_stall), .pc_step(pc_inc)
    );

    pair_slot_mux u_mux (
        .can_pair(can_pair), .issue_old(issue_old),
        .cls(e_cls), .rd(e_rd), .rs1(e_rs1), .rs2(e_rs2),
        .s_valid(s_valid), .s_src(s_src), .s_cls(s_cls),
        .s_rd(s_rd), .s_rs1(s_rs1), .s_rs2(s_rs2)
    );

    pair_load_track u_track (
        .clk(clk), .rst_n(rst_n),
        .mem_valid(s_valid[1]), .mem_cls(s_cls[1]), .mem_rd(s_rd[1]),
        .pend(pend), .pend_rd(pend_rd)
    );

    // Drive the slot outputs from the steering network.
    always_comb begin
        a_valid = s_valid[0];
        a_src   = s_src[0];
        a_cls   = s_cls[0];
        a_rd    = s_rd[0];
        a_rs1   = s_rs1[0];
        a_rs2   = s_rs2[0];
        b_valid = s_valid[1];
        b_src   = s_src[1];
        b_cls   = s_cls[1];
        b_rd    = s_rd[1];
        b_rs1   = s_rs1[1];
        b_rs2   = s_rs2[1];
        swapped = swap;
    end

    assert_slot_a_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        a_valid |-> !a_cls[1]);

    assert_slot_b_class_R2: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> b_cls[1]);

    assert_pair_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc == PAIR_STEP) == (a_valid && b_valid));

    assert_no_pair_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && b_valid && !swapped) |->
            !(writes_reg(a_cls, a_rd) && reads_reg(b_cls, b_rs1, b_rs2, a_rd)));

    assert_stall_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_stall |-> (!a_valid && !b_valid && pc_inc == '0));

    assert_load_use_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && b_cls == CLS_LOAD && b_rd != '0) |=>
            !(a_valid && reads_reg(a_cls, a_rs1, a_rs2, $past(b_rd))) &&
            !(b_valid && reads_reg(b_cls, b_rs1, b_rs2, $past(b_rd))));
endmodule

// File: tb/pair_issue_unit_bench.sv
module pair_issue_unit_bench;
    localparam int ALU = 0, BRN = 1, LD = 2, ST = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       f0_valid = 1'b0, f1_valid = 1'b0;
    logic [1:0] f0_cls = '0, f1_cls = '0;
    logic [4:0] f0_rd = '0, f0_rs1 = '0, f0_rs2 = '0;
    logic [4:0] f1_rd = '0, f1_rs1 = '0, f1_rs2 = '0;
    logic       a_valid, a_src, b_valid, b_src, swapped, load_stall;
    logic [1:0] a_cls, b_cls;
    logic [4:0] a_rd, a_rs1, a_rs2, b_rd, b_rs1, b_rs2;
    logic [3:0] pc_inc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    pair_issue_unit u_pair_issue_unit (
        .clk(clk), .rst_n(rst_n),
        .f0_valid(f0_valid), .f0_cls(f0_cls), .f0_rd(f0_rd),
        .f0_rs1(f0_rs1), .f0_rs2(f0_rs2),
        .f1_valid(f1_valid), .f1_cls(f1_cls), .f1_rd(f1_rd),
        .f1_rs1(f1_rs1), .f1_rs2(f1_rs2),
        .a_valid(a_valid), .a_src(a_src), .a_cls(a_cls), .a_rd(a_rd),
        .a_rs1(a_rs1), .a_rs2(a_rs2),
        .b_valid(b_valid), .b_src(b_src), .b_cls(b_cls), .b_rd(b_rd),
        .b_rs1(b_rs1), .b_rs2(b_rs2),
        .swapped(swapped), .pc_inc(pc_inc), .load_stall(load_stall)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Present a pair after the falling edge and let combinational outputs settle.
    task automatic put(input bit v0, input int c0, input int d0, input int s10, input int s20,
                       input bit v1, input int c1, input int d1, input int s11, input int s21);
        @(negedge clk);
        f0_valid = v0; f0_cls = 2'(c0); f0_rd = 5'(d0); f0_rs1 = 5'(s10); f0_rs2 = 5'(s20);
        f1_valid = v1; f1_cls = 2'(c1); f1_rd = 5'(d1); f1_rs1 = 5'(s11); f1_rs2 = 5'(s21);
        #2;
    endtask

    task automatic expect_out(input string req, input bit av, input bit as, input bit bv,
                              input bit bs, input bit sw, input int inc, input bit st);
        chk(req, "a_valid", int'(a_valid), int'(av));
        chk(req, "a_src", int'(a_src), int'(as));
        chk(req, "b_valid", int'(b_valid), int'(bv));
        chk(req, "b_src", int'(b_src), int'(bs));
        chk(req, "swapped", int'(swapped), int'(sw));
        chk(req, "pc_inc", int'(pc_inc), inc);
        chk(req, "load_stall", int'(load_stall), int'(st));
    endtask

    task automatic idle();
        put(0, ALU, 0, 0, 0, 0, ALU, 0, 0, 0);
    endtask

    task automatic t_reset();
        put(0, ALU, 0, 0, 0, 0, ALU, 0, 0, 0);
        expect_out("R1", 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        put(1, LD, 7, 1, 0, 0, ALU, 0, 0, 0);
        expect_out("R12", 0, 0, 1, 0, 0, 4, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        f0_valid = 1; f0_cls = 2'(ALU); f0_rd = 5'd3; f0_rs1 = 5'd7; f0_rs2 = 5'd2;
        f1_valid = 0;
        #2;
        expect_out("R1", 1, 0, 0, 0, 0, 4, 0);
    endtask

    task automatic t_inorder();
        put(1, ALU, 3, 1, 2, 1, ST, 0, 4, 5);
        expect_out("R3", 1, 0, 1, 1, 0, 8, 0);
        chk("R2", "a_cls", int'(a_cls), ALU);
        chk("R2", "a_rd", int'(a_rd), 3);
        chk("R2", "b_cls", int'(b_cls), ST);
        chk("R2", "b_rs1", int'(b_rs1), 4);
        chk("R2", "b_rs2", int'(b_rs2), 5);
    endtask

    task automatic t_swap();
        put(1, LD, 6, 1, 0, 1, BRN, 0, 2, 3);
        expect_out("R4", 1, 1, 1, 0, 1, 8, 0);
        chk("R2", "a_cls", int'(a_cls), BRN);
        chk("R2", "a_rs2", int'(a_rs2), 3);
        chk("R2", "b_cls", int'(b_cls), LD);
        chk("R2", "b_rd", int'(b_rd), 6);
        idle();
        expect_out("R12", 0, 0, 0, 0, 0, 0, 0);
        chk("R2", "empty b_rd", int'(b_rd), 0);
    endtask

    task automatic t_same();
        put(1, ALU, 3, 1, 2, 1, BRN, 0, 4, 5);
        expect_out("R5", 1, 0, 0, 0, 0, 4, 0);
        put(1, ST, 0, 1, 2, 1, LD, 9, 4, 0);
        expect_out("R5", 0, 0, 1, 0, 0, 4, 0);
    endtask

    task automatic t_raw();
        put(1, ALU, 8, 1, 2, 1, ST, 0, 3, 8);
        expect_out("R6", 1, 0, 0, 0, 0, 4, 0);
    endtask

    task automatic t_swapdep();
        put(1, LD, 9, 1, 0, 1, ALU, 4, 9, 2);
        expect_out("R7 raw", 0, 0, 1, 0, 0, 4, 0);
        idle();
        put(1, ST, 0, 10, 11, 1, ALU, 10, 2, 3);
        expect_out("R7 war", 0, 0, 1, 0, 0, 4, 0);
        put(1, LD, 12, 1, 0, 1, ALU, 12, 2, 3);
        expect_out("R7 waw", 0, 0, 1, 0, 0, 4, 0);
        idle();
        put(1, ALU, 5, 13, 2, 1, LD, 13, 3, 0);
        expect_out("R7 war unswapped", 1, 0, 1, 1, 0, 8, 0);
        idle();
    endtask

    task automatic t_loaduse_old();
        put(1, LD, 14, 1, 0, 0, ALU, 0, 0, 0);
        expect_out("R8 load", 0, 0, 1, 0, 0, 4, 0);
        put(1, ALU, 15, 14, 0, 1, ST, 0, 2, 0);
        expect_out("R8", 0, 0, 0, 0, 0, 0, 1);
        put(1, ALU, 15, 14, 0, 1, ST, 0, 2, 0);
        expect_out("R10", 1, 0, 1, 1, 0, 8, 0);
    endtask

    task automatic t_loaduse_young();
        put(1, LD, 16, 1, 0, 0, ALU, 0, 0, 0);
        expect_out("R9 load", 0, 0, 1, 0, 0, 4, 0);
        put(1, ALU, 17, 1, 2, 1, ST, 0, 16, 0);
        expect_out("R9", 1, 0, 0, 0, 0, 4, 0);
        put(1, ST, 0, 16, 0, 0, ALU, 0, 0, 0);
        expect_out("R10", 0, 0, 1, 0, 0, 4, 0);
    endtask

    task automatic t_zero_reg();
        put(1, ALU, 0, 1, 2, 1, ST, 0, 0, 0);
        expect_out("R11 pair", 1, 0, 1, 1, 0, 8, 0);
        put(1, LD, 0, 1, 0, 0, ALU, 0, 0, 0);
        expect_out("R11 load", 0, 0, 1, 0, 0, 4, 0);
        put(1, ALU, 4, 0, 0, 0, ALU, 0, 0, 0);
        expect_out("R11 use", 1, 0, 0, 0, 0, 4, 0);
    endtask

    task automatic t_read_sets();
        put(1, ALU, 21, 1, 2, 1, LD, 22, 3, 21);
        expect_out("R13 load rs2", 1, 0, 1, 1, 0, 8, 0);
        idle();
        put(1, BRN, 23, 1, 2, 1, ST, 0, 23, 0);
        expect_out("R13 branch rd", 1, 0, 1, 1, 0, 8, 0);
        put(1, ST, 24, 1, 2, 1, ALU, 25, 24, 0);
        expect_out("R13 store rd", 1, 1, 1, 0, 1, 8, 0);
    endtask

    task automatic t_valid();
        put(0, ALU, 3, 1, 2, 1, ST, 0, 4, 5);
        expect_out("R12 no old", 0, 0, 0, 0, 0, 0, 0);
        put(1, BRN, 0, 1, 2, 0, LD, 6, 1, 0);
        expect_out("R12 no young", 1, 0, 0, 0, 0, 4, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_inorder();
        t_swap();
        t_same();
        t_raw();
        t_swapdep();
        t_loaduse_old();
        t_loaduse_young();
        t_zero_reg();
        t_read_sets();
        t_valid();
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule